// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block feeds a transmit path from a ring of descriptors held in system memory. Each descriptor takes two 32-bit words: a buffer address word followed by a control word. After software raises the enable level and pulses start, the block reads descriptors in ring order. It fetches the bytes of each buffer through a simple word-wide read port and presents them one byte per cycle on a byte stream that carries frame-start and frame-end markers.

A frame can span several descriptors. Buffers are joined until one descriptor carries the last-buffer flag. When a frame is finished, the block hands ownership back to software. It does this by rewriting the control word of the frame's first descriptor with the used bit set, and it pulses a completion interrupt in the same cycle.

A descriptor that is still owned by software (used bit already set) ends the run. If that happens in the middle of a frame, the block also marks the frame's first descriptor as corrupted. A halt pulse lets the current frame finish and then stops. Dropping the enable level stops the block at once and rewinds it to the start of the ring.

Top module: `txring_reader`

## Requirements
- R1: With `tx_enable` high, a `tx_start` pulse makes the block read the descriptor at `ring_base` plus the current ring offset. The address word is at +0 and the control word at +4, and descriptors are 8 bytes apart. The first byte of a non-empty buffer appears on `out_data` five clock edges after the edge that samples `tx_start`.
- R2: Control word bits 13:0 give the byte count of a buffer. The buffer address has its low two bits ignored. Each memory word is emitted least significant byte first. `out_sof` marks the first emitted byte of a frame. `out_eof` marks the final byte of the descriptor whose control bit 15 (last buffer) is set.
- R3: Buffers of consecutive descriptors are joined into one frame until bit 15 appears. At the end of the frame, the control word of the frame's first descriptor is written back with bit 31 (used) set and all other bits kept, in the same cycle as an `irq_tx_done` pulse. No other descriptor is written.
- R4: If the frame's first descriptor has control bit 16 set, `out_no_crc` is high on every byte of that frame. Otherwise it is low on every byte.
- R5: Reading a control word with bit 31 set pulses `irq_used_read`, emits no byte and returns the block to idle. The ring offset stays on that descriptor, so the next start reads it again.
- R6: If the descriptor that stops the run arrives in the middle of a frame, the frame's first control word is written back with bits 31 and 27 set. `irq_tx_corrupt` and `irq_used_read` pulse together.
- R7: A `tx_halt` pulse during a run lets the frame in progress complete, including its write-back, and then the block goes idle. The next start continues with the following descriptor.
- R8: After a descriptor with control bit 30 (wrap) set, the next descriptor is read at `ring_base`.
- R9: A descriptor with length zero and without bit 15 is skipped and emits no byte. A zero-length descriptor with bit 15 closes the frame (write-back and `irq_tx_done`) without emitting a byte.
- R10: While `tx_enable` is low the block is idle one edge later, ignores `tx_start`, and resets the ring offset to the base.
- R11: After reset the block is idle, with no memory access, no byte output and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_enable | input | 1 | Transmit enable level; low rewinds the ring |
| tx_start | input | 1 | Start pulse |
| tx_halt | input | 1 | Halt-after-frame pulse |
| ring_base | input | ADDR_W | Byte address of descriptor 0 (8-byte aligned) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| mem_wr_en | output | 1 | Descriptor write-back strobe |
| mem_wr_addr | output | ADDR_W | Write-back byte address |
| mem_wr_data | output | 32 | Write-back control word |
| out_valid | output | 1 | Byte valid |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| out_no_crc | output | 1 | Frame must go out without CRC |
| irq_tx_done | output | 1 | Frame complete pulse |
| irq_used_read | output | 1 | Used descriptor read pulse |
| irq_tx_corrupt | output | 1 | Frame cut short pulse |
| busy | output | 1 | Run in progress |

## Verification
The memory model answers a read one cycle after the request. The first byte of a buffer is therefore due five edges after the start edge, and the bench samples the stream on the falling edge of both the fourth and the fifth cycle to pin this down. The write-back and its interrupt fall in the same cycle. The bench counts interrupts and captures bytes on every falling edge, so no pulse is missed. Each scenario then waits for `busy` to drop before comparing byte streams, flag positions, interrupt counts and descriptor words in memory against values computed from the descriptors it wrote. Ignored inputs are checked at the ports: a start while disabled must leave `busy` low, and a disabled block's ring offset is checked by observing which buffer the next run sends.

// File: rtl/txring_pkg.sv
package txring_pkg;
    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int LANES      = WORD_W / BYTE_W;
    localparam int LANE_W     = $clog2(LANES);
    localparam int LEN_W      = 14;
    localparam int DESC_BYTES = 8;
    localparam int CTRL_OFS   = 4;

    // Control word field positions (decoded by software as well)
    localparam int BIT_USED    = 31;
    localparam int BIT_WRAP    = 30;
    localparam int BIT_CORRUPT = 27;
    localparam int BIT_NOCRC   = 16;
    localparam int BIT_LAST    = 15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_CTRL,
        ST_DECODE,
        ST_DATA_RD,
        ST_DATA_CAP,
        ST_EMIT,
        ST_WRITEBACK
    } ring_state_e;
endpackage

// File: rtl/txring_byte_sel.sv
module txring_byte_sel
    import txring_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic [BYTE_W-1:0] lane_bytes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[g*BYTE_W +: BYTE_W];
    end

    assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/txring_wb_word.sv
module txring_wb_word
    import txring_pkg::*;
(
    input  logic [WORD_W-1:0] ctrl_i,
    input  logic              corrupt_i,
    output logic [WORD_W-1:0] word_o
);
    always_comb begin
        word_o = ctrl_i;
        word_o[BIT_USED] = 1'b1;
        if (corrupt_i) begin
            word_o[BIT_CORRUPT] = 1'b1;
        end
    end
endmodule

// File: rtl/txring_fsm.sv
module txring_fsm
    import txring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              tx_start,
    input  logic              tx_halt,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wb_ctrl,
    output logic              wb_corrupt,
    output logic [WORD_W-1:0] cur_word,
    output logic [LANE_W-1:0] cur_lane,
    output logic              o_valid,
    output logic              o_sof,
    output logic              o_eof,
    output logic              o_no_crc,
    output logic              irq_done,
    output logic              irq_used,
    output logic              irq_corrupt,
    output logic              o_busy
);
    typedef struct packed {
        ring_state_e         st;
        logic [OFF_W-1:0]    off;
        logic [OFF_W-1:0]    first_off;
        logic [WORD_W-1:0]   first_ctrl;
        logic [ADDR_W-1:0]   buf_addr;
        logic [LEN_W-1:0]    remain;
        logic [WORD_W-1:0]   word;
        logic [LANE_W-1:0]   lane;
        logic                in_frame;
        logic                last;
        logic                no_crc;
        logic                sof_pend;
        logic                halt_pend;
    } ring_regs_t;

    localparam logic [OFF_W-1:0]  OFF_STEP  = OFF_W'(DESC_BYTES);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(LANES);
    localparam logic [LANE_W-1:0] LANE_TOP  = LANE_W'(LANES - 1);
    localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);

    ring_regs_t r_d, r_q;

    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] first_ctrl_addr;
    logic [LEN_W-1:0]  dec_len;

    assign desc_addr       = ring_base + ADDR_W'(r_q.off);
    assign first_ctrl_addr = ring_base + ADDR_W'(r_q.first_off) + ADDR_W'(CTRL_OFS);
    assign dec_len         = rd_data[LEN_W-1:0];

    always_comb begin
        r_d         = r_q;
        rd_en       = 1'b0;
        rd_addr     = desc_addr;
        wr_en       = 1'b0;
        wr_addr     = first_ctrl_addr;
        wb_corrupt  = 1'b0;
        o_valid     = 1'b0;
        o_sof       = 1'b0;
        o_eof       = 1'b0;
        irq_done    = 1'b0;
        irq_used    = 1'b0;
        irq_corrupt = 1'b0;

        if (tx_halt && r_q.st != ST_IDLE) begin
            r_d.halt_pend = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                if (tx_start) begin
                    r_d.st        = ST_RD_ADDR;
                    r_d.halt_pend = 1'b0;
                end
            end
            ST_RD_ADDR: begin
                rd_en    = 1'b1;
                rd_addr  = desc_addr;
                r_d.st   = ST_RD_CTRL;
            end
            ST_RD_CTRL: begin
                rd_en        = 1'b1;
                rd_addr      = desc_addr + ADDR_W'(CTRL_OFS);
                r_d.buf_addr = {rd_data[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                r_d.st       = ST_DECODE;
            end
            ST_DECODE: begin
                if (rd_data[BIT_USED]) begin
                    irq_used = 1'b1;
                    if (r_q.in_frame) begin
                        wr_en       = 1'b1;
                        wb_corrupt  = 1'b1;
                        irq_corrupt = 1'b1;
                    end
                    r_d.in_frame = 1'b0;
                    r_d.st       = ST_IDLE;
                end else begin
                    if (!r_q.in_frame) begin
                        r_d.in_frame   = 1'b1;
                        r_d.first_off  = r_q.off;
                        r_d.first_ctrl = rd_data;
                        r_d.no_crc     = rd_data[BIT_NOCRC];
                        r_d.sof_pend   = 1'b1;
                    end
                    r_d.last   = rd_data[BIT_LAST];
                    r_d.remain = dec_len;
                    r_d.lane   = '0;
                    r_d.off    = rd_data[BIT_WRAP] ? '0 : r_q.off + OFF_STEP;
                    if (dec_len != '0) begin
                        r_d.st = ST_DATA_RD;
                    end else if (rd_data[BIT_LAST]) begin
                        r_d.st = ST_WRITEBACK;
                    end else begin
                        r_d.st = ST_RD_ADDR;
                    end
                end
            end
            ST_DATA_RD: begin
                rd_en   = 1'b1;
                rd_addr = r_q.buf_addr;
                r_d.st  = ST_DATA_CAP;
            end
            ST_DATA_CAP: begin
                r_d.word = rd_data;
                r_d.st   = ST_EMIT;
            end
            ST_EMIT: begin
                o_valid      = 1'b1;
                o_sof        = r_q.sof_pend;
                o_eof        = r_q.last && (r_q.remain == LEN_ONE);
                r_d.sof_pend = 1'b0;
                r_d.remain   = r_q.remain - LEN_ONE;
                if (r_q.remain == LEN_ONE) begin
                    r_d.st = r_q.last ? ST_WRITEBACK : ST_RD_ADDR;
                end else if (r_q.lane == LANE_TOP) begin
                    r_d.lane     = '0;
                    r_d.buf_addr = r_q.buf_addr + WORD_STEP;
                    r_d.st       = ST_DATA_RD;
                end else begin
                    r_d.lane = r_q.lane + LANE_W'(1);
                end
            end
            ST_WRITEBACK: begin
                wr_en        = 1'b1;
                irq_done     = 1'b1;
                r_d.in_frame = 1'b0;
                if (r_q.halt_pend || tx_halt) begin
                    r_d.st        = ST_IDLE;
                    r_d.halt_pend = 1'b0;
                end else begin
                    r_d.st = ST_RD_ADDR;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (!tx_enable) begin
            r_d.st        = ST_IDLE;
            r_d.off       = '0;
            r_d.in_frame  = 1'b0;
            r_d.halt_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign wb_ctrl  = r_q.first_ctrl;
    assign cur_word = r_q.word;
    assign cur_lane = r_q.lane;
    assign o_no_crc = o_valid & r_q.no_crc;
    assign o_busy   = (r_q.st != ST_IDLE);
endmodule

// File: rtl/txring_reader.sv
module txring_reader
    import txring_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              tx_start,
    input  logic              tx_halt,
    input  logic [ADDR_W-1:0] ring_base,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [31:0]       mem_wr_data,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_no_crc,
    output logic              irq_tx_done,
    output logic              irq_used_read,
    output logic              irq_tx_corrupt,
    output logic              busy
);
    logic [WORD_W-1:0] wb_ctrl;
    logic              wb_corrupt;
    logic [WORD_W-1:0] cur_word;
    logic [LANE_W-1:0] cur_lane;

    txring_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .tx_start    (tx_start),
        .tx_halt     (tx_halt),
        .ring_base   (ring_base),
        .rd_data     (mem_rd_data),
        .rd_en       (mem_rd_en),
        .rd_addr     (mem_rd_addr),
        .wr_en       (mem_wr_en),
        .wr_addr     (mem_wr_addr),
        .wb_ctrl     (wb_ctrl),
        .wb_corrupt  (wb_corrupt),
        .cur_word    (cur_word),
        .cur_lane    (cur_lane),
        .o_valid     (out_valid),
        .o_sof       (out_sof),
        .o_eof       (out_eof),
        .o_no_crc    (out_no_crc),
        .irq_done    (irq_tx_done),
        .irq_used    (irq_used_read),
        .irq_corrupt (irq_tx_corrupt),
        .o_busy      (busy)
    );

    txring_byte_sel u_bsel (
        .word_i (cur_word),
        .lane_i (cur_lane),
        .byte_o (out_data)
    );

    txring_wb_word u_wbw (
        .ctrl_i    (wb_ctrl),
        .corrupt_i (wb_corrupt),
        .word_o    (mem_wr_data)
    );
endmodule

// File: rtl/txring_reader_chk.sv
module txring_reader_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_enable,
    input logic              tx_start,
    input logic              tx_halt,
    input logic [ADDR_W-1:0] ring_base,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic [31:0]       mem_rd_data,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic [31:0]       mem_wr_data,
    input logic              out_valid,
    input logic [7:0]        out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_no_crc,
    input logic              irq_tx_done,
    input logic              irq_used_read,
    input logic              irq_tx_corrupt,
    input logic              busy
);
    assert_done_writes_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_done |-> (mem_wr_en && mem_wr_data[31]));

    assert_done_corrupt_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_tx_done, irq_tx_corrupt}));

    assert_corrupt_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx_corrupt |-> (mem_wr_en && mem_wr_data[31] && mem_wr_data[27] && irq_used_read));

    assert_used_no_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_used_read |-> !out_valid);

    assert_used_ends_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_used_read && tx_enable |=> !busy);

    assert_eof_with_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eof || out_sof || out_no_crc) |-> out_valid);

    assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enable |=> !busy);

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !mem_rd_en && !mem_wr_en));
endmodule

bind txring_reader txring_reader_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_txring_reader.sv
module sim_txring_reader;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE  = 32'h40;
    localparam logic [31:0] USED  = 32'h8000_0000;
    localparam logic [31:0] WRAP  = 32'h4000_0000;
    localparam logic [31:0] COR   = 32'h0800_0000;
    localparam logic [31:0] NOCRC = 32'h0001_0000;
    localparam logic [31:0] LAST  = 32'h0000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_enable = 1'b0;
    logic        tx_start = 1'b0;
    logic        tx_halt = 1'b0;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [31:0] mem_rd_data = '0;
    logic        out_valid, out_sof, out_eof, out_no_crc;
    logic [7:0]  out_data;
    logic        irq_tx_done, irq_used_read, irq_tx_corrupt, busy;

    logic        tb_we = 1'b0;
    logic [31:0] tb_waddr = '0, tb_wdata = '0;
    logic [31:0] mem [0:255];

    int nchk = 0, nerr = 0;
    int cap_n = 0, n_done = 0, n_used = 0, n_cor = 0;
    logic [7:0] cap_d [0:1023];
    logic       cap_s [0:1023];
    logic       cap_e [0:1023];
    logic       cap_c [0:1023];
    int m_cap, m_done, m_used, m_cor;

    always #(CLK_PERIOD/2) clk = ~clk;

    txring_reader u0 (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start),
        .tx_halt(tx_halt), .ring_base(BASE),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_no_crc(out_no_crc), .irq_tx_done(irq_tx_done), .irq_used_read(irq_used_read),
        .irq_tx_corrupt(irq_tx_corrupt), .busy(busy)
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 13 + 5) & 255);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < 256; w++)
                mem[w] <= {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
        end else begin
            if (tb_we) mem[tb_waddr[9:2]] <= tb_wdata;
            if (mem_wr_en) mem[mem_wr_addr[9:2]] <= mem_wr_data;
        end
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                cap_d[cap_n] = out_data;
                cap_s[cap_n] = out_sof;
                cap_e[cap_n] = out_eof;
                cap_c[cap_n] = out_no_crc;
                if (cap_n < 1023) cap_n++;
            end
            if (irq_tx_done) n_done++;
            if (irq_used_read) n_used++;
            if (irq_tx_corrupt) n_cor++;
        end
    end

    task automatic check_eq(string req, string what, longint act, longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic poke(logic [31:0] a, logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic set_desc(int i, logic [31:0] a, logic [31:0] c);
        poke(BASE + 32'(8*i), a);
        poke(BASE + 32'(8*i + 4), c);
    endtask

    function automatic logic [31:0] ctrl_of(int i);
        return mem[(BASE + 32'(8*i + 4)) >> 2];
    endfunction

    task automatic snap();
        m_cap = cap_n; m_done = n_done; m_used = n_used; m_cor = n_cor;
    endtask

    task automatic rewind();
        @(negedge clk) tx_enable = 1'b0;
        @(negedge clk) tx_enable = 1'b1;
    endtask

    task automatic pulse_start();
        @(negedge clk) tx_start = 1'b1;
        @(negedge clk) tx_start = 1'b0;
    endtask

    task automatic wait_idle(string req);
        int k = 0;
        @(negedge clk);
        while (busy && k < 3000) begin
            @(negedge clk);
            k++;
        end
        check_eq(req, "run ends idle", longint'(busy), 0);
    endtask

    task automatic wait_byte();
        int k = 0;
        while (!out_valid && k < 200) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic check_bytes(string req, int from, int addr, int len);
        int bad = 0;
        for (int i = 0; i < len; i++)
            if (cap_d[from + i] != pat(addr + i)) bad++;
        check_eq(req, "byte mismatches", bad, 0);
    endtask

    function automatic int count_flag(int from, int len, int which);
        int n = 0;
        for (int i = from; i < from + len; i++) begin
            if (which == 0 && cap_s[i]) n++;
            if (which == 1 && cap_e[i]) n++;
            if (which == 2 && cap_c[i]) n++;
        end
        return n;
    endfunction

    task automatic t_reset();
        check_eq("R11", "busy after reset", longint'(busy), 0);
        check_eq("R11", "no byte after reset", longint'(out_valid), 0);
        check_eq("R11", "no read after reset", longint'(mem_rd_en), 0);
        check_eq("R11", "no irq after reset", longint'({irq_tx_done, irq_used_read, irq_tx_corrupt}), 0);
    endtask

    task automatic t_single();
        rewind();
        set_desc(0, 32'h200, LAST | 32'd6);
        set_desc(1, 32'h0, USED);
        snap();
        @(negedge clk) tx_start = 1'b1;
        @(posedge clk);
        @(negedge clk) tx_start = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "no byte before edge 5", longint'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        check_eq("R1", "first byte at edge 5", longint'(out_valid && out_sof), 1);
        wait_idle("R1");
        check_eq("R2", "byte count", cap_n - m_cap, 6);
        check_bytes("R2", m_cap, 32'h200, 6);
        check_eq("R2", "sof position", longint'(cap_s[m_cap]), 1);
        check_eq("R2", "single eof at end", longint'(cap_e[m_cap+5]) + count_flag(m_cap, 6, 1), 2);
        check_eq("R3", "write-back", ctrl_of(0), LAST | USED | 32'd6);
        check_eq("R3", "done irqs", n_done - m_done, 1);
        check_eq("R5", "used irq ends ring", n_used - m_used, 1);
    endtask

    task automatic t_multi();
        rewind();
        set_desc(0, 32'h200, 32'd5);
        set_desc(1, 32'h281, LAST | 32'd3);
        set_desc(2, 32'h0, USED);
        snap();
        pulse_start();
        wait_idle("R3");
        check_eq("R3", "joined bytes", cap_n - m_cap, 8);
        check_bytes("R3", m_cap, 32'h200, 5);
        check_bytes("R2", m_cap + 5, 32'h280, 3);
        check_eq("R2", "sof count", count_flag(m_cap, 8, 0), 1);
        check_eq("R2", "eof on final byte", longint'(cap_e[m_cap+7]) + count_flag(m_cap, 8, 1), 2);
        check_eq("R3", "first desc written", ctrl_of(0), USED | 32'd5);
        check_eq("R3", "second desc untouched", ctrl_of(1), LAST | 32'd3);
        check_eq("R3", "one done irq", n_done - m_done, 1);
    endtask

    task automatic t_nocrc();
        rewind();
        set_desc(0, 32'h200, NOCRC | 32'd4);
        set_desc(1, 32'h280, LAST | 32'd2);
        set_desc(2, 32'h300, LAST | 32'd3);
        set_desc(3, 32'h0, USED);
        snap();
        pulse_start();
        wait_idle("R4");
        check_eq("R4", "byte count", cap_n - m_cap, 9);
        check_eq("R4", "no-crc on frame 1", count_flag(m_cap, 6, 2), 6);
        check_eq("R4", "no-crc off frame 2", count_flag(m_cap + 6, 3, 2), 0);
        check_eq("R4", "two frames", n_done - m_done, 2);
    endtask

    task automatic t_used();
        rewind();
        set_desc(0, 32'h200, USED | LAST | 32'd2);
        snap();
        pulse_start();
        wait_idle("R5");
        check_eq("R5", "no bytes", cap_n - m_cap, 0);
        check_eq("R5", "used irq", n_used - m_used, 1);
        check_eq("R5", "no done", n_done - m_done, 0);
        set_desc(0, 32'h300, LAST | 32'd2);
        set_desc(1, 32'h0, USED);
        snap();
        pulse_start();
        wait_idle("R5");
        check_eq("R5", "same desc reread", cap_n - m_cap, 2);
        check_bytes("R5", m_cap, 32'h300, 2);
    endtask

    task automatic t_corrupt();
        rewind();
        set_desc(0, 32'h200, 32'd3);
        set_desc(1, 32'h0, USED);
        snap();
        pulse_start();
        wait_idle("R6");
        check_eq("R6", "partial bytes", cap_n - m_cap, 3);
        check_eq("R6", "no eof", count_flag(m_cap, 3, 1), 0);
        check_eq("R6", "corrupt write-back", ctrl_of(0), USED | COR | 32'd3);
        check_eq("R6", "corrupt irq", n_cor - m_cor, 1);
        check_eq("R6", "used irq", n_used - m_used, 1);
        check_eq("R6", "no done", n_done - m_done, 0);
    endtask

    task automatic t_halt();
        rewind();
        set_desc(0, 32'h200, LAST | 32'd12);
        set_desc(1, 32'h280, LAST | 32'd4);
        set_desc(2, 32'h0, USED);
        snap();
        pulse_start();
        wait_byte();
        @(negedge clk) tx_halt = 1'b1;
        @(negedge clk) tx_halt = 1'b0;
        wait_idle("R7");
        check_eq("R7", "frame finished", cap_n - m_cap, 12);
        check_eq("R7", "one done", n_done - m_done, 1);
        check_eq("R7", "halted not used", n_used - m_used, 0);
        check_eq("R7", "frame written back", ctrl_of(0), USED | LAST | 32'd12);
        snap();
        pulse_start();
        wait_idle("R7");
        check_eq("R7", "resume next desc", cap_n - m_cap, 4);
        check_bytes("R7", m_cap, 32'h280, 4);
    endtask

    task automatic t_wrap();
        rewind();
        set_desc(0, 32'h200, LAST | 32'd2);
        set_desc(1, 32'h280, LAST | WRAP | 32'd3);
        snap();
        pulse_start();
        wait_idle("R8");
        check_eq("R8", "two frames", n_done - m_done, 2);
        check_eq("R8", "wrapped to used desc0", n_used - m_used, 1);
        check_eq("R8", "bytes", cap_n - m_cap, 5);
        set_desc(0, 32'h300, LAST | 32'd4);
        snap();
        pulse_start();
        wait_idle("R8");
        check_eq("R8", "restart at base", cap_n - m_cap, 4);
        check_bytes("R8", m_cap, 32'h300, 4);
    endtask

    task automatic t_zero();
        rewind();
        set_desc(0, 32'h200, 32'd0);
        set_desc(1, 32'h280, LAST | 32'd3);
        set_desc(2, 32'h300, LAST);
        set_desc(3, 32'h0, USED);
        snap();
        pulse_start();
        wait_idle("R9");
        check_eq("R9", "only real bytes", cap_n - m_cap, 3);
        check_bytes("R9", m_cap, 32'h280, 3);
        check_eq("R9", "sof on first", longint'(cap_s[m_cap]), 1);
        check_eq("R9", "two frames closed", n_done - m_done, 2);
        check_eq("R9", "skip desc owns frame", ctrl_of(0), USED);
        check_eq("R9", "empty last written", ctrl_of(2), USED | LAST);
    endtask

    task automatic t_disable();
        rewind();
        set_desc(0, 32'h200, LAST | 32'd40);
        set_desc(1, 32'h0, USED);
        pulse_start();
        wait_byte();
        @(negedge clk) tx_enable = 1'b0;
        @(negedge clk);
        check_eq("R10", "idle after disable", longint'(busy), 0);
        check_eq("R10", "no write-back", ctrl_of(0), LAST | 32'd40);
        pulse_start();
        @(negedge clk);
        check_eq("R10", "start ignored", longint'(busy), 0);
        @(negedge clk) tx_enable = 1'b1;
        set_desc(0, 32'h300, LAST | 32'd2);
        snap();
        pulse_start();
        wait_idle("R10");
        check_eq("R10", "offset rewound", cap_n - m_cap, 2);
        check_bytes("R10", m_cap, 32'h300, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        tx_enable = 1'b1;
        t_single();
        t_multi();
        t_nocrc();
        t_used();
        t_corrupt();
        t_halt();
        t_wrap();
        t_zero();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule